// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the control-unit state machine that walks a processor through one instruction at a time. Each instruction passes through up to seven named sub-phases: next-address calculation, fetch, decode, operand address calculation, operand fetch, data operation and result store. A final interrupt-check phase is added to the end of every instruction. The operand phases are skipped when the instruction has no memory or I/O operand. The store phase is skipped when the instruction writes no result out.

The surrounding datapath gives the sequencer a decoded class for the instruction during decode. The class has three bits: memory operand, store and jump. It also gives a memory-ready handshake and an interrupt-pending line. In return the sequencer drives one-hot phase strobes, load enables for the program counter and the instruction register, a program-counter source select, and a context-save strobe. A pending interrupt is remembered until the check phase takes it. Taking it saves context and points the program counter at the handler before the next fetch begins.

Top module: `instr_cycle_seq`

## Requirements
- R1: A synchronous reset puts the sequencer in the address-calculation phase and clears any remembered interrupt. A later interrupt check with no new request therefore does not redirect.
- R2: Exactly one bit of `phase_onehot` is high in every cycle. The bit order is: bit0 address calculation, bit1 fetch, bit2 decode, bit3 operand address, bit4 operand fetch, bit5 data operation, bit6 store, bit7 interrupt check.
- R3: The address-calculation phase lasts one cycle and is always followed by fetch.
- R4: Fetch holds until `mem_ready` is high. In the cycle when fetch completes, `ir_load` and `pc_load` are high and `pc_sel` is 1 (increment). Decode follows.
- R5: The class inputs are sampled in decode. A memory-operand class goes to operand address and then operand fetch. Any other class goes straight to data operation.
- R6: Operand fetch holds until `mem_ready` is high, then moves to data operation.
- R7: In the data-operation cycle of a jump-class instruction, `pc_load` is high and `pc_sel` is 2 (branch target).
- R8: After data operation, a store-class instruction spends exactly one cycle in store and then goes to interrupt check. Any other instruction goes directly to interrupt check.
- R9: In interrupt check with an interrupt pending, `ctx_save` and `pc_load` are high and `pc_sel` is 3 (handler) in that cycle. With no interrupt pending, none of the three is active. Address calculation always follows.
- R10: A request on `irq_pending` in any cycle is remembered until the next interrupt check takes it. A request that arrives during the check cycle itself is taken at once. A taken request is cleared.
- R11: Outside the cycles named in R4, R7 and R9, `pc_load` is low and `pc_sel` is 0. The class inputs have no effect outside decode, and `mem_ready` has no effect outside fetch and operand fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cls_mem_operand | input | 1 | Decoded class: instruction references a memory or I/O operand |
| cls_store | input | 1 | Decoded class: instruction writes its result to memory or I/O |
| cls_jump | input | 1 | Decoded class: instruction transfers control |
| mem_ready | input | 1 | Memory completes the current access this cycle |
| irq_pending | input | 1 | Interrupt request |
| phase_onehot | output | 8 | One-hot phase strobes, bit order as in R2 |
| ir_load | output | 1 | Load instruction register |
| pc_load | output | 1 | Load program counter |
| pc_sel | output | 2 | Program counter source: 0 hold, 1 increment, 2 branch target, 3 handler |
| ctx_save | output | 1 | Save the interrupted context |

## Verification
The load, select and context-save outputs are combinational from the current phase and the live `mem_ready` and `irq_pending`, so they are due in the same cycle as the stimulus. A phase change appears on the strobes one clock edge after the input that causes it. The bench drives inputs just after the falling edge and compares every output 1 ns later against a behavioural model that holds the current phase. The model then advances at the rising edge from the inputs that were driven. During every instruction the class inputs are inverted outside decode and `mem_ready` toggles outside the memory phases, so the per-cycle comparison shows that they have no effect there.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

  localparam int NUM_PHASES = 8;
  localparam int PHASE_W    = $clog2(NUM_PHASES);
  localparam int PCSEL_W    = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_IAC  = 3'd0,
    PH_IF   = 3'd1,
    PH_IOD  = 3'd2,
    PH_OAC  = 3'd3,
    PH_OF   = 3'd4,
    PH_DO   = 3'd5,
    PH_OS   = 3'd6,
    PH_INTC = 3'd7
  } phase_t;

  typedef enum logic [PCSEL_W-1:0] {
    PCS_HOLD = 2'd0,
    PCS_INC  = 2'd1,
    PCS_JMP  = 2'd2,
    PCS_HDL  = 2'd3
  } pcsel_t;

  // Successor of a phase. live_mem is the class bit seen during decode,
  // held_store is the store bit captured at decode.
  function automatic phase_t phase_after(input phase_t cur, input logic rdy,
                                         input logic live_mem, input logic held_store);
    phase_t nx;
    case (cur)
      PH_IAC:  nx = PH_IF;
      PH_IF:   nx = rdy ? PH_IOD : PH_IF;
      PH_IOD:  nx = live_mem ? PH_OAC : PH_DO;
      PH_OAC:  nx = PH_OF;
      PH_OF:   nx = rdy ? PH_DO : PH_OF;
      PH_DO:   nx = held_store ? PH_OS : PH_INTC;
      PH_OS:   nx = PH_INTC;
      default: nx = PH_IAC;
    endcase
    return nx;
  endfunction

  // Program counter source for the current cycle.
  function automatic pcsel_t pc_source(input phase_t cur, input logic rdy,
                                       input logic held_jump, input logic take);
    pcsel_t s;
    s = PCS_HOLD;
    if (cur == PH_IF && rdy)            s = PCS_INC;
    else if (cur == PH_DO && held_jump) s = PCS_JMP;
    else if (cur == PH_INTC && take)    s = PCS_HDL;
    return s;
  endfunction

endpackage

// File: rtl/icyc_irq_latch.sv
module icyc_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic irq_in,
  input  logic take,
  output logic pend_eff
);
  logic pend_q;

  assign pend_eff = pend_q | irq_in;

  always_ff @(posedge clk) begin
    if (rst)       pend_q <= 1'b0;
    else if (take) pend_q <= 1'b0;
    else           pend_q <= pend_eff;
  end
endmodule

// File: rtl/icyc_next.sv
module icyc_next
  import icyc_pkg::*;
(
  input  phase_t cur,
  input  logic   rdy,
  input  logic   live_mem,
  input  logic   held_store,
  output phase_t nxt,
  output logic   mem_stall
);
  assign nxt       = phase_after(cur, rdy, live_mem, held_store);
  assign mem_stall = ((cur == PH_IF) || (cur == PH_OF)) && !rdy;
endmodule

// File: rtl/icyc_strobes.sv
module icyc_strobes
  import icyc_pkg::*;
(
  input  phase_t                cur,
  input  logic                  rdy,
  input  logic                  held_jump,
  input  logic                  take,
  output logic [NUM_PHASES-1:0] onehot,
  output logic                  ir_load,
  output logic                  pc_load,
  output pcsel_t                sel,
  output logic                  ctx_save
);
  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_strobe
    assign onehot[i] = (PHASE_W'(i) == cur);
  end

  assign sel      = pc_source(cur, rdy, held_jump, take);
  assign pc_load  = (sel != PCS_HOLD);
  assign ir_load  = (sel == PCS_INC);
  assign ctx_save = (sel == PCS_HDL);
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import icyc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cls_mem_operand,
  input  logic                  cls_store,
  input  logic                  cls_jump,
  input  logic                  mem_ready,
  input  logic                  irq_pending,
  output logic [NUM_PHASES-1:0] phase_onehot,
  output logic                  ir_load,
  output logic                  pc_load,
  output logic [PCSEL_W-1:0]    pc_sel,
  output logic                  ctx_save
);
  phase_t cur_q;
  phase_t nxt;
  logic   held_store_q;
  logic   held_jump_q;
  logic   pend_eff;
  logic   take_irq;
  logic   mem_stall;
  logic   decode_now;
  pcsel_t sel_w;

  assign decode_now = (cur_q == PH_IOD);
  assign take_irq   = (cur_q == PH_INTC) && pend_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q        <= PH_IAC;
      held_store_q <= 1'b0;
      held_jump_q  <= 1'b0;
    end else begin
      cur_q <= nxt;
      if (decode_now) begin
        held_store_q <= cls_store;
        held_jump_q  <= cls_jump;
      end
    end
  end

  icyc_irq_latch u_irq (
    .clk      (clk),
    .rst      (rst),
    .irq_in   (irq_pending),
    .take     (take_irq),
    .pend_eff (pend_eff)
  );

  icyc_next u_next (
    .cur        (cur_q),
    .rdy        (mem_ready),
    .live_mem   (cls_mem_operand),
    .held_store (held_store_q),
    .nxt        (nxt),
    .mem_stall  (mem_stall)
  );

  icyc_strobes u_strb (
    .cur       (cur_q),
    .rdy       (mem_ready),
    .held_jump (held_jump_q),
    .take      (take_irq),
    .onehot    (phase_onehot),
    .ir_load   (ir_load),
    .pc_load   (pc_load),
    .sel       (sel_w),
    .ctx_save  (ctx_save)
  );

  assign pc_sel = sel_w;
endmodule

// File: rtl/icyc_checker.sv
module icyc_checker (
  input logic       clk,
  input logic       rst,
  input logic       cls_mem_operand,
  input logic       mem_ready,
  input logic [7:0] phase_onehot,
  input logic       ir_load,
  input logic       pc_load,
  input logic [1:0] pc_sel,
  input logic       ctx_save,
  input logic       mem_stall,
  input logic       take_irq
);
  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_onehot) == 1);

  // R3
  iac_once_chk: assert property (@(posedge clk) disable iff (rst)
    phase_onehot[0] |=> phase_onehot[1]);

  // R4
  if_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_onehot[1] && !mem_ready) |=> phase_onehot[1]);

  // R4
  fetch_load_chk: assert property (@(posedge clk) disable iff (rst)
    ir_load |-> (pc_load && pc_sel == 2'd1 && phase_onehot[1]));

  // R5
  skip_opnd_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_onehot[2] && !cls_mem_operand) |=> phase_onehot[5]);

  // R6
  of_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_onehot[4] && !mem_ready) |=> phase_onehot[4]);

  // R6
  stall_stable_chk: assert property (@(posedge clk) disable iff (rst)
    mem_stall |=> $stable(phase_onehot));

  // R8
  os_once_chk: assert property (@(posedge clk) disable iff (rst)
    phase_onehot[6] |=> phase_onehot[7]);

  // R9
  ctx_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    ctx_save |-> (pc_load && pc_sel == 2'd3 && take_irq));

  // R9
  ctx_then_iac_chk: assert property (@(posedge clk) disable iff (rst)
    phase_onehot[7] |=> phase_onehot[0]);

  // R11
  idle_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_onehot[0] || phase_onehot[2] || phase_onehot[3] ||
     phase_onehot[4] || phase_onehot[6]) |-> (!pc_load && pc_sel == 2'd0));
endmodule

bind instr_cycle_seq icyc_checker u_chk (
  .clk             (clk),
  .rst             (rst),
  .cls_mem_operand (cls_mem_operand),
  .mem_ready       (mem_ready),
  .phase_onehot    (phase_onehot),
  .ir_load         (ir_load),
  .pc_load         (pc_load),
  .pc_sel          (pc_sel),
  .ctx_save        (ctx_save),
  .mem_stall       (mem_stall),
  .take_irq        (take_irq)
);

// File: tb/instr_cycle_seq_test.sv
`timescale 1ns/1ps
module instr_cycle_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       c_mem = 1'b0, c_st = 1'b0, c_jp = 1'b0, rdy = 1'b0, irq = 1'b0;
  logic [7:0] oh;
  logic       irl, pcl, ctx;
  logic [1:0] sel;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string tag = "R1";

  // behavioural reference state
  int m_ph = 0;
  bit m_pend = 0, m_st = 0, m_jp = 0;

  always #2.5 clk = ~clk;

  instr_cycle_seq uut (
    .clk(clk), .rst(rst), .cls_mem_operand(c_mem), .cls_store(c_st),
    .cls_jump(c_jp), .mem_ready(rdy), .irq_pending(irq),
    .phase_onehot(oh), .ir_load(irl), .pc_load(pcl), .pc_sel(sel), .ctx_save(ctx)
  );

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input bit r, input bit mo, input bit st, input bit jp,
                      input bit rd, input bit iq);
    bit       pe;
    bit [7:0] e_oh;
    bit [1:0] e_sel;
    @(negedge clk);
    rst = r; c_mem = mo; c_st = st; c_jp = jp; rdy = rd; irq = iq;
    #1;
    pe = m_pend | iq;
    if (!r) begin
      e_oh  = 8'd1 << m_ph;
      e_sel = 2'd0;
      if (m_ph == 1 && rd)      e_sel = 2'd1;
      else if (m_ph == 5 && m_jp) e_sel = 2'd2;
      else if (m_ph == 7 && pe) e_sel = 2'd3;
      chk("phase", oh, e_oh);
      chk("ir_load", {7'd0, irl}, {7'd0, e_sel == 2'd1});
      chk("pc_load", {7'd0, pcl}, {7'd0, e_sel != 2'd0});
      chk("pc_sel", {6'd0, sel}, {6'd0, e_sel});
      chk("ctx_save", {7'd0, ctx}, {7'd0, e_sel == 2'd3});
    end
    @(posedge clk);
    if (r) begin
      m_ph = 0; m_pend = 0; m_st = 0; m_jp = 0;
    end else begin
      if (m_ph == 7 && pe) m_pend = 0;
      else                 m_pend = pe;
      case (m_ph)
        0: m_ph = 1;
        1: if (rd) m_ph = 2;
        2: begin m_st = st; m_jp = jp; m_ph = mo ? 3 : 5; end
        3: m_ph = 4;
        4: if (rd) m_ph = 5;
        5: m_ph = m_st ? 6 : 7;
        6: m_ph = 7;
        default: m_ph = 0;
      endcase
    end
  endtask

  // One full instruction; class bits are inverted outside decode (R11 noise).
  task automatic run_instr(input bit mo, input bit st, input bit jp, input int irq_at,
                           input int wif, input int wof, input string t);
    int n = 0, wi = 0, wo = 0;
    bit last, rd, dec;
    tag = t;
    do begin
      last = (m_ph == 7);
      dec  = (m_ph == 2);
      if (m_ph == 1)      begin rd = (wi >= wif); wi++; end
      else if (m_ph == 4) begin rd = (wo >= wof); wo++; end
      else                rd = n[0];
      tick(1'b0, dec ? mo : ~mo, dec ? st : ~st, dec ? jp : ~jp, rd, n == irq_at);
      n++;
    end while (!last);
  endtask

  initial begin
    repeat (3) tick(1'b1, 0, 0, 0, 0, 1);
    // R1: reset state, and an interrupt raised during reset is not remembered
    run_instr(0, 0, 0, -1, 0, 0, "R1");
    // R3: plain instruction
    run_instr(0, 0, 0, -1, 0, 0, "R3");
    // R4: fetch waits
    run_instr(0, 0, 0, -1, 4, 0, "R4");
    // R5: operand phases taken
    run_instr(1, 0, 0, -1, 0, 0, "R5");
    // R6: operand fetch waits
    run_instr(1, 0, 0, -1, 2, 5, "R6");
    // R7: jumps
    run_instr(0, 0, 1, -1, 1, 0, "R7");
    run_instr(1, 1, 1, -1, 0, 1, "R7");
    // R8: store phase
    run_instr(0, 1, 0, -1, 0, 0, "R8");
    run_instr(1, 1, 0, -1, 0, 3, "R8");
    // R10: early pulse remembered, then cleared after being taken
    run_instr(1, 1, 0, 2, 0, 0, "R10");
    run_instr(0, 0, 0, -1, 0, 0, "R10");
    // R9: request arriving in the check cycle itself (cycle index 4)
    run_instr(0, 0, 0, 4, 0, 0, "R9");
    run_instr(0, 0, 1, -1, 0, 0, "R9");
    // R11: noise on class and ready everywhere else
    run_instr(1, 1, 1, -1, 2, 2, "R11");
    // R2: every class combination
    for (int k = 0; k < 8; k++) run_instr(k[0], k[1], k[2], k % 3, k % 2, 1, "R2");
    // R1: reset mid-instruction drops a remembered request
    tag = "R1";
    tick(1'b0, 0, 0, 0, 0, 1);
    tick(1'b0, 0, 0, 0, 1, 0);
    tick(1'b1, 0, 0, 0, 0, 0);
    tick(1'b1, 0, 0, 0, 0, 0);
    run_instr(0, 0, 0, -1, 0, 0, "R1");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog %s: actual hung expected finished", tag);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule